// File: doc/BRIEF.md
# Reconfigurable ALU/Shift Cell

This block is one cell of a reconfigurable execution array that sits beside a processor pipeline. Each cycle it receives a configuration word that chooses two operands, an arithmetic or logic operation, a shift, the order in which the two are chained, and whether the result is kept. The operands can come from four register-file values, the result of a neighbouring complex unit, the result of the adjacent cell, or this cell's own stored result. Feeding back its own result lets a short dataflow graph accumulate over several configuration steps.

The cell returns its result in two forms. A combinational result and carry serve as the input to another cell in the same cycle. A registered result is kept for later steps. Add and subtract use a parallel-prefix adder. The shifter is a chain of power-of-two multiplexer stages. Both ALU-then-shift and shift-then-ALU finish in one cycle.

All pins are plain per-cycle control and data. The configuration word is the only control: it has no handshake and no back-pressure, and a new word is taken on every clock.

Top module: `rcell_top`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `res_o` to zero.
- R2: At a rising edge with `rst` low, `res_o` takes the value of `comb_o` when the write-enable field (cfg bit 13) is 1. When that bit is 0, `res_o` keeps its value.
- R3: The operand-A select field (cfg bits 2:0) and the operand-B select field (cfg bits 5:3) use the same encoding: 0 to 3 pick `rf0_i` to `rf3_i`, 4 picks `cplx_i`, 5 picks `nbr_i`, 6 picks the cell's own registered result, and 7 gives zero.
- R4: The ALU field (cfg bits 8:6) selects AND=2 (A&B), OR=3 (A|B), XOR=4 (A^B), NOT=5 (~A), pass A=6 and pass B=7.
- R5: ALU code 0 gives A+B and code 1 gives A+~B+1. For these two codes `carry_o` is the adder carry-out, so for a subtract it is 1 exactly when there is no borrow. For every other ALU code `carry_o` is 0.
- R6: The shift field (cfg bits 10:9) selects logical left=1, logical right=2 and arithmetic right=3. Only the arithmetic right shift fills with the sign bit.
- R7: The shift amount comes from the immediate field (cfg bits 18:14) when the amount-select bit (cfg bit 11) is 1. When that bit is 0, it comes from bits 4:0 of operand B.
- R8: When the order bit (cfg bit 12) is 0, the ALU result is shifted. When it is 1, operand A is shifted first and the shifted value goes into the ALU as its A input together with operand B.
- R9: Shift code 0 passes its input through unchanged, so `comb_o` is then the plain ALU result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_i | input | 19 | Configuration word for this cycle |
| rf0_i | input | 32 | Register-file operand 0 |
| rf1_i | input | 32 | Register-file operand 1 |
| rf2_i | input | 32 | Register-file operand 2 |
| rf3_i | input | 32 | Register-file operand 3 |
| cplx_i | input | 32 | Result of the complex unit |
| nbr_i | input | 32 | Result of the neighbouring cell |
| comb_o | output | 32 | Combinational result, for chaining |
| carry_o | output | 1 | Adder carry-out |
| res_o | output | 32 | Registered result |

## Verification
The in-RTL properties check the following on every cycle, by comparing the ports with arithmetic written independently of the datapath:
- the register's load, hold and reset rules;
- add and subtract with their carry;
- the AND result;
- the three shift kinds when the ALU passes A.

Some behaviour only the bench scenarios can show: the decoding of every operand source, including self-feedback accumulation over several cycles; the shift-then-ALU order; and the choice between the immediate amount and the amount taken from operand B.

// File: rtl/rcell_pkg.sv
package rcell_pkg;
  localparam int CELL_W = 32;

  typedef enum logic [2:0] {
    SRC_RF0, SRC_RF1, SRC_RF2, SRC_RF3, SRC_CPLX, SRC_NBR, SRC_SELF, SRC_ZERO
  } src_e;

  typedef enum logic [2:0] {
    OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOT, OP_PASSA, OP_PASSB
  } aop_e;

  typedef enum logic [1:0] {
    SH_NONE, SH_SLL, SH_SRL, SH_SRA
  } sop_e;
endpackage

// File: rtl/rcell_psadd.sv
module rcell_psadd #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int LG = $clog2(W);

  logic [W-1:0] gg [0:LG];
  logic [W-1:0] pp [0:LG];
  logic [W:0]   cc;

  assign gg[0] = a & b;
  assign pp[0] = a ^ b;

  // Sklansky prefix tree: upper half of each 2^(l+1) block joins the lower half's top bit
  for (genvar l = 0; l < LG; l++) begin : g_lvl
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (((i >> l) & 1) == 1) begin : g_join
        localparam int J = ((i >> l) << l) - 1;
        assign gg[l+1][i] = gg[l][i] | (pp[l][i] & gg[l][J]);
        assign pp[l+1][i] = pp[l][i] & pp[l][J];
      end else begin : g_keep
        assign gg[l+1][i] = gg[l][i];
        assign pp[l+1][i] = pp[l][i];
      end
    end
  end

  assign cc[0] = cin;
  for (genvar i = 0; i < W; i++) begin : g_carry
    assign cc[i+1] = gg[LG][i] | (pp[LG][i] & cin);
  end

  assign sum  = pp[0] ^ cc[W-1:0];
  assign cout = cc[W];
endmodule

// File: rtl/rcell_alu.sv
module rcell_alu
  import rcell_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  aop_e         op,
  output logic [W-1:0] res,
  output logic         carry
);
  logic         is_sub;
  logic [W-1:0] add_sum;
  logic         add_co;

  assign is_sub = (op == OP_SUB);

  rcell_psadd #(.W(W)) u_add (
    .a   (x),
    .b   (is_sub ? ~y : y),
    .cin (is_sub),
    .sum (add_sum),
    .cout(add_co)
  );

  always_comb begin
    carry = 1'b0;
    unique case (op)
      OP_ADD, OP_SUB: begin res = add_sum; carry = add_co; end
      OP_AND:   res = x & y;
      OP_OR:    res = x | y;
      OP_XOR:   res = x ^ y;
      OP_NOT:   res = ~x;
      OP_PASSA: res = x;
      default:  res = y;
    endcase
  end
endmodule

// File: rtl/rcell_shift.sv
module rcell_shift
  import rcell_pkg::*;
#(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   din,
  input  sop_e           op,
  input  logic [SHW-1:0] amt,
  output logic [W-1:0]   dout
);
  logic [W-1:0] rev_in, rev_out;
  logic [W-1:0] st [0:SHW];
  logic         fill;

  // left shift reuses the right-shift stages on bit-reversed data
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign rev_in[i]  = din[W-1-i];
    assign rev_out[i] = st[SHW][W-1-i];
  end

  assign fill  = (op == SH_SRA) ? din[W-1] : 1'b0;
  assign st[0] = (op == SH_SLL) ? rev_in : din;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int S = 1 << k;
    assign st[k+1] = amt[k] ? {{S{fill}}, st[k][W-1:S]} : st[k];
  end

  always_comb begin
    unique case (op)
      SH_NONE: dout = din;
      SH_SLL:  dout = rev_out;
      default: dout = st[SHW];
    endcase
  end
endmodule

// File: rtl/rcell_chain.sv
module rcell_chain
  import rcell_pkg::*;
#(
  parameter int W           = 32,
  parameter int SHW         = $clog2(W),
  parameter bit SHIFT_FIRST = 1'b0
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  aop_e           aop,
  input  sop_e           sop,
  input  logic [SHW-1:0] amt,
  output logic [W-1:0]   y,
  output logic           carry
);
  logic [W-1:0] mid;

  if (SHIFT_FIRST) begin : g_sh_alu
    rcell_shift #(.W(W), .SHW(SHW)) u_sh (.din(a), .op(sop), .amt(amt), .dout(mid));
    rcell_alu   #(.W(W)) u_alu (.x(mid), .y(b), .op(aop), .res(y), .carry(carry));
  end else begin : g_alu_sh
    rcell_alu   #(.W(W)) u_alu (.x(a), .y(b), .op(aop), .res(mid), .carry(carry));
    rcell_shift #(.W(W), .SHW(SHW)) u_sh (.din(mid), .op(sop), .amt(amt), .dout(y));
  end
endmodule

// File: rtl/rcell_top.sv
module rcell_top
  import rcell_pkg::*;
#(
  parameter  int W     = CELL_W,
  localparam int SHW   = $clog2(W),
  localparam int CFG_W = 14 + SHW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic [W-1:0]     rf0_i,
  input  logic [W-1:0]     rf1_i,
  input  logic [W-1:0]     rf2_i,
  input  logic [W-1:0]     rf3_i,
  input  logic [W-1:0]     cplx_i,
  input  logic [W-1:0]     nbr_i,
  output logic [W-1:0]     comb_o,
  output logic             carry_o,
  output logic [W-1:0]     res_o
);
  // configuration field decode
  src_e           sel_a, sel_b;
  aop_e           aop;
  sop_e           sop;
  logic           amt_imm, order, we;
  logic [SHW-1:0] imm;

  assign sel_a   = src_e'(cfg_i[2:0]);
  assign sel_b   = src_e'(cfg_i[5:3]);
  assign aop     = aop_e'(cfg_i[8:6]);
  assign sop     = sop_e'(cfg_i[10:9]);
  assign amt_imm = cfg_i[11];
  assign order   = cfg_i[12];
  assign we      = cfg_i[13];
  assign imm     = cfg_i[14 +: SHW];

  logic [W-1:0]   res_q;
  logic [W-1:0]   op_a, op_b;
  logic [SHW-1:0] amt;

  function automatic logic [W-1:0] pick(input src_e s, input logic [W-1:0] r0,
      input logic [W-1:0] r1, input logic [W-1:0] r2, input logic [W-1:0] r3,
      input logic [W-1:0] cx, input logic [W-1:0] nb, input logic [W-1:0] me);
    unique case (s)
      SRC_RF0:  return r0;
      SRC_RF1:  return r1;
      SRC_RF2:  return r2;
      SRC_RF3:  return r3;
      SRC_CPLX: return cx;
      SRC_NBR:  return nb;
      SRC_SELF: return me;
      default:  return '0;
    endcase
  endfunction

  assign op_a = pick(sel_a, rf0_i, rf1_i, rf2_i, rf3_i, cplx_i, nbr_i, res_q);
  assign op_b = pick(sel_b, rf0_i, rf1_i, rf2_i, rf3_i, cplx_i, nbr_i, res_q);
  assign amt  = amt_imm ? imm : op_b[SHW-1:0];

  // one datapath per chaining order; order bit picks the result
  logic [W-1:0] path_y [2];
  logic [1:0]   path_c;

  for (genvar g = 0; g < 2; g++) begin : g_path
    rcell_chain #(.W(W), .SHW(SHW), .SHIFT_FIRST(g == 1)) u_chain (
      .a    (op_a),
      .b    (op_b),
      .aop  (aop),
      .sop  (sop),
      .amt  (amt),
      .y    (path_y[g]),
      .carry(path_c[g])
    );
  end

  assign comb_o  = order ? path_y[1] : path_y[0];
  assign carry_o = order ? path_c[1] : path_c[0];

  always_ff @(posedge clk) begin
    if (rst)     res_q <= '0;
    else if (we) res_q <= comb_o;
  end

  assign res_o = res_q;

  // ---- checks next to the result register ----
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (res_o == '0));
  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    we |=> (res_o == $past(comb_o)));
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(res_o));

  // ---- checks on the arithmetic and shift path ----
  assert_add_R5: assert property (@(posedge clk) disable iff (rst)
    (!order && sop == SH_NONE && aop == OP_ADD) |->
      ({carry_o, comb_o} == ({1'b0, op_a} + {1'b0, op_b})));
  assert_sub_R5: assert property (@(posedge clk) disable iff (rst)
    (!order && sop == SH_NONE && aop == OP_SUB) |->
      (comb_o == W'(op_a - op_b) && carry_o == (op_a >= op_b)));
  assert_no_carry_R5: assert property (@(posedge clk) disable iff (rst)
    (aop != OP_ADD && aop != OP_SUB) |-> !carry_o);
  assert_and_R4: assert property (@(posedge clk) disable iff (rst)
    (!order && sop == SH_NONE && aop == OP_AND) |-> (comb_o == (op_a & op_b)));
  assert_sll_R6: assert property (@(posedge clk) disable iff (rst)
    (aop == OP_PASSA && sop == SH_SLL) |-> (comb_o == (op_a << amt)));
  assert_srl_R6: assert property (@(posedge clk) disable iff (rst)
    (aop == OP_PASSA && sop == SH_SRL) |-> (comb_o == (op_a >> amt)));
  assert_sra_R6: assert property (@(posedge clk) disable iff (rst)
    (aop == OP_PASSA && sop == SH_SRA) |-> (comb_o == W'($signed(op_a) >>> amt)));
endmodule

// File: tb/test_rcell_top.sv
`timescale 1ns/1ps
module test_rcell_top;
  localparam int W = 32;
  localparam int CFG_W = 19;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CFG_W-1:0] cfg = '0;
  logic [W-1:0]     rf0 = '0, rf1 = '0;
  logic [W-1:0]     rf2 = 32'h0000_0010, rf3 = 32'hF0F0_0000;
  logic [W-1:0]     cplx = 32'h1234_5678, nbr = 32'h8000_0001;
  logic [W-1:0]     comb, res;
  logic             carry;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  rcell_top i_rcell_top (
    .clk(clk), .rst(rst), .cfg_i(cfg),
    .rf0_i(rf0), .rf1_i(rf1), .rf2_i(rf2), .rf3_i(rf3),
    .cplx_i(cplx), .nbr_i(nbr),
    .comb_o(comb), .carry_o(carry), .res_o(res)
  );

  // fields: [2:0] A src, [5:3] B src, [8:6] alu, [10:9] shift,
  // [11] amount-from-imm, [12] order, [13] write, [18:14] imm
  function automatic logic [CFG_W-1:0] mk(int sa, int sb, int aop, int sop,
      int asel, int imm, int ord, int we);
    return {imm[4:0], we[0], ord[0], asel[0], sop[1:0], aop[2:0], sb[2:0], sa[2:0]};
  endfunction

  typedef struct packed {
    logic [CFG_W-1:0] cfg;
    logic [W-1:0]     a;
    logic [W-1:0]     b;
    logic [W-1:0]     exp;
    logic             c;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{mk(0,1,0,0,0,0,0,1), 32'h5,         32'h7,         32'hC,         1'b0}, // R5 add
    '{mk(0,1,0,0,0,0,0,1), 32'hFFFF_FFFF, 32'h1,         32'h0,         1'b1}, // R5 add carry
    '{mk(0,1,1,0,0,0,0,1), 32'hA,         32'h3,         32'h7,         1'b1}, // R5 sub no borrow
    '{mk(0,1,1,0,0,0,0,1), 32'h3,         32'hA,         32'hFFFF_FFF9, 1'b0}, // R5 sub borrow
    '{mk(0,1,1,0,0,0,0,1), 32'h5,         32'h5,         32'h0,         1'b1}, // R5 sub equal
    '{mk(0,1,2,0,0,0,0,1), 32'hF0F0_F0F0, 32'hFF00_FF00, 32'hF000_F000, 1'b0}, // R4 and
    '{mk(0,1,3,0,0,0,0,1), 32'hF0F0_F0F0, 32'hFF00_FF00, 32'hFFF0_FFF0, 1'b0}, // R4 or
    '{mk(0,1,4,0,0,0,0,1), 32'hF0F0_F0F0, 32'hFF00_FF00, 32'h0FF0_0FF0, 1'b0}, // R4 xor
    '{mk(0,1,5,0,0,0,0,1), 32'hF0F0_F0F0, 32'hFF00_FF00, 32'h0F0F_0F0F, 1'b0}, // R4 not
    '{mk(4,1,6,0,0,0,0,1), 32'h0,         32'h0,         32'h1234_5678, 1'b0}, // R3 complex, R9
    '{mk(0,5,7,0,0,0,0,1), 32'h0,         32'h0,         32'h8000_0001, 1'b0}, // R3 neighbour
    '{mk(0,7,0,0,0,0,0,1), 32'h9,         32'h55,        32'h9,         1'b0}, // R3 zero
    '{mk(2,3,0,0,0,0,0,1), 32'h0,         32'h0,         32'hF0F0_0010, 1'b0}, // R3 rf2+rf3
    '{mk(0,1,6,1,1,31,0,1),32'h1,         32'h0,         32'h8000_0000, 1'b0}, // R6 sll
    '{mk(0,1,6,2,1,4,0,1), 32'h8000_0000, 32'h0,         32'h0800_0000, 1'b0}, // R6 srl
    '{mk(0,1,6,3,1,4,0,1), 32'h8000_0000, 32'h0,         32'hF800_0000, 1'b0}, // R6 sra
    '{mk(0,1,6,1,0,7,0,1), 32'h1,         32'h23,        32'h8,         1'b0}, // R7 amount from B
    '{mk(0,1,0,1,1,4,1,1), 32'h1,         32'h3,         32'h13,        1'b0}, // R8 shift then add
    '{mk(0,1,0,1,1,4,0,1), 32'h1,         32'h3,         32'h40,        1'b0}, // R8 add then shift
    '{mk(0,1,1,3,1,8,0,1), 32'h0,         32'h1,         32'hFFFF_FFFF, 1'b0}, // R8 sub then sra
    '{mk(0,1,0,3,0,0,1,1), 32'h8000_0000, 32'h4,         32'hF800_0004, 1'b0}  // R7 R8 sra by B then add
  };

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [CFG_W-1:0] c, logic [W-1:0] a, logic [W-1:0] b);
    @(negedge clk);
    cfg = c; rf0 = a; rf1 = b;
    #2;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (whole run) actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset value", res, '0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].cfg, VEC[i].a, VEC[i].b);
      chk($sformatf("vector %0d comb (R3..R9)", i), comb, VEC[i].exp);
      chk($sformatf("vector %0d carry R5", i), {31'b0, carry}, {31'b0, VEC[i].c});
      tick();
      chk($sformatf("vector %0d R2 load", i), res, VEC[i].exp);
    end

    // R3 self feedback accumulates
    drive(mk(0,1,6,0,0,0,0,1), 32'd100, 32'd0);
    tick();
    drive(mk(6,1,0,0,0,0,0,1), 32'd0, 32'd1);
    tick();
    chk("R3 self feedback step 1", res, 32'd101);
    drive(mk(6,1,0,0,0,0,0,1), 32'd0, 32'd1);
    tick();
    chk("R3 self feedback step 2", res, 32'd102);

    // R2 hold with write-enable low, comb still live
    drive(mk(0,1,6,0,0,0,0,0), 32'hDEAD_BEEF, 32'd0);
    chk("R2 comb with we low", comb, 32'hDEAD_BEEF);
    tick();
    chk("R2 hold", res, 32'd102);

    // R1 reset in mid-run
    drive(mk(0,1,6,0,0,0,0,1), 32'h7777_7777, 32'd0);
    rst = 1'b1;
    tick();
    chk("R1 reset clears", res, '0);
    @(negedge clk);
    rst = 1'b0;
    tick();
    chk("R2 load after reset", res, 32'h7777_7777);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule